// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Threshold Interrupts

This block holds the byte queues that sit between a UART's serial shifters and the host. It has one receive queue, filled by the receive shifter and drained by the host, and one transmit queue, filled by the host and drained by the transmit shifter. Both face their neighbours through plain push and pop byte ports. A write-only 8-bit control word sets the behaviour. It switches both queues between FIFO operation and single-entry holding registers. It can empty either path in the cycle of the write. It also selects, from fixed tables that depend on the queue depth, the fill level that raises each path's interrupt.

The receive interrupt reports that enough bytes are waiting. The transmit interrupt reports that the transmit queue has drained below its mark. The transmit mark only applies when the extended-mode input is high. Without extended mode, the transmit interrupt simply means "empty". The depth parameter may be 16 or 32.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset, both fill levels are 0, both overrun outputs are 0, both read-data outputs are 0, FIFO mode is off and every threshold code is 00.
- R2: With control bit 0 clear, each path holds at most one byte. With bit 0 set, each path holds up to DEPTH bytes and returns them in push order.
- R3: A control write with bit 0 = 0 empties both paths in the cycle of the write, overriding any push or pop in that cycle.
- R4: A control write with bit 1 = 1 empties the receive path in the cycle of the write. It overrides a receive push or pop in that cycle and leaves the transmit path unchanged. The bit is not stored, so the next cycle accepts pushes normally.
- R5: A control write with bit 2 = 1 does the same for the transmit path and leaves the receive path unchanged.
- R6: Bit 3 of the control word has no effect on levels, data or interrupts.
- R7: Bits 7:6 select the receive threshold. For codes 00/01/10/11 it is 1/4/8/14 at depth 16 and 1/8/16/26 at depth 32. The receive interrupt is high while the receive level is greater than or equal to that threshold.
- R8: Bits 5:4 select the transmit threshold. For codes 00/01/10/11 it is 1/3/9/13 at depth 16 and 1/7/17/25 at depth 32. With extended mode high, the transmit interrupt is high while the transmit level is below that threshold.
- R9: With extended mode low, bits 5:4 are ignored and the transmit interrupt is high exactly when the transmit level is 0.
- R10: A push to a full path is dropped and gives a one-cycle overrun pulse on the next cycle. A push together with an accepted pop on a full path is accepted without overrun.
- R11: An accepted pop presents the oldest byte on read data in the next cycle. A pop from an empty path changes neither the read data nor the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word |
| ext_mode | input | 1 | Extended mode: enables the transmit threshold |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_pdata | input | 8 | Byte from the receive shifter |
| rx_pop | input | 1 | Host takes a received byte |
| rx_rdata | output | 8 | Last byte taken from the receive path |
| tx_push | input | 1 | Host queues a byte for transmission |
| tx_pdata | input | 8 | Byte from the host |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_rdata | output | 8 | Last byte taken from the transmit path |
| rx_level | output | LW | Receive fill level |
| tx_level | output | LW | Transmit fill level |
| rx_ovr | output | 1 | Receive overrun pulse |
| tx_ovr | output | 1 | Transmit overrun pulse |
| rx_irq | output | 1 | Receive threshold interrupt |
| tx_irq | output | 1 | Transmit threshold interrupt |

## Verification
The effect of each push, pop or control write is registered at one clock edge. Levels, read data and overrun pulses are therefore due one edge after the stimulus. Both interrupts follow the levels combinationally, so they change together with the levels. The bench applies every stimulus on a falling edge and samples all outputs at the next falling edge, with exactly one rising edge in between. It sweeps each path from empty to one push past full and back for every threshold code, and compares the results with values computed from the tables in the requirements.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

   // control word fields
   localparam int CB_EN      = 0;
   localparam int CB_RX_CLR  = 1;
   localparam int CB_TX_CLR  = 2;
   localparam int CB_TX_LO   = 4;
   localparam int CB_RX_LO   = 6;

   typedef struct packed {
      logic [1:0] rx_code;
      logic [1:0] tx_code;
      logic       fifo_on;
   } uf_ctl_t;

endpackage

// File: rtl/uf_ctl_reg.sv
module uf_ctl_reg
   import uart_fifo_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wdata,
   output uf_ctl_t    ctl,
   output logic       rx_clr,
   output logic       tx_clr
);

   logic flush_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (we) begin
         ctl.fifo_on <= wdata[CB_EN];
         ctl.tx_code <= wdata[CB_TX_LO +: 2];
         ctl.rx_code <= wdata[CB_RX_LO +: 2];
      end
   end

   // clear strobes act in the write cycle and are never stored
   assign flush_all = we & ~wdata[CB_EN];
   assign rx_clr    = flush_all | (we & wdata[CB_RX_CLR]);
   assign tx_clr    = flush_all | (we & wdata[CB_TX_CLR]);

endmodule

// File: rtl/uf_thr_select.sv
module uf_thr_select #(
   parameter int DEPTH   = 16,
   parameter bit RX_SIDE = 1'b1,
   localparam int LW     = $clog2(DEPTH + 1)
) (
   input  logic [1:0]    code,
   output logic [LW-1:0] thr
);

   generate
      if (DEPTH != 16 && DEPTH != 32) begin : g_bad_depth
         $error("uf_thr_select: DEPTH must be 16 or 32");
      end
      if (DEPTH == 16 && RX_SIDE) begin : g_rx16
         always_comb
            case (code)
               2'd0:    thr = LW'(1);
               2'd1:    thr = LW'(4);
               2'd2:    thr = LW'(8);
               default: thr = LW'(14);
            endcase
      end else if (DEPTH == 16) begin : g_tx16
         always_comb
            case (code)
               2'd0:    thr = LW'(1);
               2'd1:    thr = LW'(3);
               2'd2:    thr = LW'(9);
               default: thr = LW'(13);
            endcase
      end else if (RX_SIDE) begin : g_rx32
         always_comb
            case (code)
               2'd0:    thr = LW'(1);
               2'd1:    thr = LW'(8);
               2'd2:    thr = LW'(16);
               default: thr = LW'(26);
            endcase
      end else begin : g_tx32
         always_comb
            case (code)
               2'd0:    thr = LW'(1);
               2'd1:    thr = LW'(7);
               2'd2:    thr = LW'(17);
               default: thr = LW'(25);
            endcase
      end
   endgenerate

endmodule

// File: rtl/uf_fifo_core.sv
module uf_fifo_core #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          single,
   input  logic          push,
   input  logic [DW-1:0] pdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [LW-1:0] level,
   output logic          ovr
);

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_pow2
         $error("uf_fifo_core: DEPTH must be a power of two");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [LW-1:0] cap;
   logic          full, pop_ok, push_ok;

   assign cap     = single ? LW'(1) : LW'(DEPTH);
   assign full    = (level >= cap);
   assign pop_ok  = pop & (level != '0);
   assign push_ok = push & (~full | pop_ok);

   always_ff @(posedge clk) begin
      if (push_ok && !clr) mem[wr_ptr] <= pdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         rdata  <= '0;
         ovr    <= 1'b0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         rdata  <= '0;
         ovr    <= 1'b0;
      end else begin
         ovr <= push & ~push_ok;
         if (push_ok) wr_ptr <= wr_ptr + AW'(1);
         if (pop_ok) begin
            rd_ptr <= rd_ptr + AW'(1);
            rdata  <= mem[rd_ptr];
         end
         case ({push_ok, pop_ok})
            2'b10:   level <= level + LW'(1);
            2'b01:   level <= level - LW'(1);
            default: level <= level;
         endcase
      end
   end

   // R2
   level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));
   // R3
   clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (level == '0));
   // R10
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |-> $past(push));
   // R11
   pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !clr && level == '0) |=> ($stable(rdata) && level == '0));

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
   import uart_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_we,
   input  logic [7:0]    ctl_wdata,
   input  logic          ext_mode,
   input  logic          rx_push,
   input  logic [DW-1:0] rx_pdata,
   input  logic          rx_pop,
   output logic [DW-1:0] rx_rdata,
   input  logic          tx_push,
   input  logic [DW-1:0] tx_pdata,
   input  logic          tx_pop,
   output logic [DW-1:0] tx_rdata,
   output logic [LW-1:0] rx_level,
   output logic [LW-1:0] tx_level,
   output logic          rx_ovr,
   output logic          tx_ovr,
   output logic          rx_irq,
   output logic          tx_irq
);

   uf_ctl_t       ctl;
   logic          rx_clr, tx_clr;
   logic [LW-1:0] rx_thr, tx_thr;

   uf_ctl_reg i_ctl (
      .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
      .ctl(ctl), .rx_clr(rx_clr), .tx_clr(tx_clr)
   );

   uf_fifo_core #(.DW(DW), .DEPTH(DEPTH)) i_rx (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .single(~ctl.fifo_on),
      .push(rx_push), .pdata(rx_pdata), .pop(rx_pop),
      .rdata(rx_rdata), .level(rx_level), .ovr(rx_ovr)
   );

   uf_fifo_core #(.DW(DW), .DEPTH(DEPTH)) i_tx (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr), .single(~ctl.fifo_on),
      .push(tx_push), .pdata(tx_pdata), .pop(tx_pop),
      .rdata(tx_rdata), .level(tx_level), .ovr(tx_ovr)
   );

   uf_thr_select #(.DEPTH(DEPTH), .RX_SIDE(1'b1)) i_rx_thr (
      .code(ctl.rx_code), .thr(rx_thr)
   );

   uf_thr_select #(.DEPTH(DEPTH), .RX_SIDE(1'b0)) i_tx_thr (
      .code(ctl.tx_code), .thr(tx_thr)
   );

   assign rx_irq = (rx_level >= rx_thr);
   assign tx_irq = ext_mode ? (tx_level < tx_thr) : (tx_level == '0);

   // R9
   tx_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_mode && tx_level != '0) |-> !tx_irq);
   // R7
   rx_empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |-> !rx_irq);
   // R4
   rx_clr_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_wdata[CB_EN] && ctl_wdata[CB_RX_CLR] && !ctl_wdata[CB_TX_CLR]
       && !tx_push && !tx_pop) |=> $stable(tx_level));

endmodule

// File: tb/test_uart_fifo_pair.sv
module test_uart_fifo_pair;

   localparam int DEPTH = 16;
   localparam int LW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_we = 1'b0;
   logic [7:0]    ctl_wdata = '0;
   logic          ext_mode = 1'b0;
   logic          rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
   logic [7:0]    rx_pdata = '0, tx_pdata = '0;
   logic [7:0]    rx_rdata, tx_rdata;
   logic [LW-1:0] rx_level, tx_level;
   logic          rx_ovr, tx_ovr, rx_irq, tx_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int rx_t16 [4] = '{1, 4, 8, 14};
   int tx_t16 [4] = '{1, 3, 9, 13};

   always #2 clk = ~clk;

   uart_fifo_pair #(.DEPTH(DEPTH)) i_uart_fifo_pair (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ext_mode(ext_mode),
      .rx_push(rx_push), .rx_pdata(rx_pdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
      .tx_push(tx_push), .tx_pdata(tx_pdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
      .rx_level(rx_level), .tx_level(tx_level), .rx_ovr(rx_ovr), .tx_ovr(tx_ovr),
      .rx_irq(rx_irq), .tx_irq(tx_irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // inputs set before the call; one rising edge passes; sample at the falling edge
   task automatic cyc();
      @(negedge clk);
      ctl_we = 1'b0; rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
   endtask

   task automatic wr_ctl(input logic [7:0] w);
      ctl_we = 1'b1; ctl_wdata = w;
      cyc();
   endtask

   initial begin
      #400000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int exp_lvl;
      int sav;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 rx_level", int'(rx_level), 0);
      chk("R1 tx_level", int'(tx_level), 0);
      chk("R1 rx_ovr", int'(rx_ovr), 0);
      chk("R1 rx_rdata", int'(rx_rdata), 0);
      chk("R1 rx_irq", int'(rx_irq), 0);
      chk("R1 tx_irq empty non-ext", int'(tx_irq), 1);

      // R2 disabled: single holding entry
      rx_push = 1'b1; rx_pdata = 8'hA1; cyc();
      chk("R2 hold level", int'(rx_level), 1);
      rx_push = 1'b1; rx_pdata = 8'hA2; cyc();
      chk("R2 hold level stays 1", int'(rx_level), 1);
      chk("R10 overrun in hold mode", int'(rx_ovr), 1);
      rx_pop = 1'b1; cyc();
      chk("R2 hold data", int'(rx_rdata), 'hA1);
      chk("R10 overrun one cycle", int'(rx_ovr), 0);

      // R7 R2 R10 R11 receive sweep over every threshold code
      for (int c = 0; c < 4; c++) begin
         wr_ctl(8'((c << 6) | 8'h03));
         chk("R4 rx cleared by write", int'(rx_level), 0);
         for (int n = 1; n <= DEPTH + 1; n++) begin
            rx_push = 1'b1; rx_pdata = 8'(n + 32 * c); cyc();
            exp_lvl = (n > DEPTH) ? DEPTH : n;
            chk("R2 rx level", int'(rx_level), exp_lvl);
            chk("R7 rx_irq", int'(rx_irq), int'(exp_lvl >= rx_t16[c]));
            chk("R10 rx_ovr", int'(rx_ovr), int'(n > DEPTH));
         end
         if (c == 0) begin
            rx_push = 1'b1; rx_pop = 1'b1; rx_pdata = 8'hEE; cyc();
            chk("R10 push+pop on full level", int'(rx_level), DEPTH);
            chk("R10 push+pop on full no ovr", int'(rx_ovr), 0);
            chk("R11 oldest byte", int'(rx_rdata), 1);
            for (int k = 2; k <= DEPTH; k++) begin
               rx_pop = 1'b1; cyc();
               chk("R11 rx order", int'(rx_rdata), k);
            end
            rx_pop = 1'b1; cyc();
            chk("R11 last pushed byte", int'(rx_rdata), 'hEE);
         end else begin
            for (int k = 1; k <= DEPTH; k++) begin
               rx_pop = 1'b1; cyc();
               chk("R11 rx order", int'(rx_rdata), k + 32 * c);
               chk("R7 rx_irq draining", int'(rx_irq), int'((DEPTH - k) >= rx_t16[c]));
            end
         end
         sav = int'(rx_rdata);
         rx_pop = 1'b1; cyc();
         chk("R11 pop empty rdata", int'(rx_rdata), sav);
         chk("R11 pop empty level", int'(rx_level), 0);
      end

      // R8 transmit sweep, extended mode
      ext_mode = 1'b1;
      for (int c = 0; c < 4; c++) begin
         wr_ctl(8'((c << 4) | 8'h05));
         chk("R5 tx cleared by write", int'(tx_level), 0);
         chk("R8 tx_irq empty", int'(tx_irq), 1);
         for (int n = 1; n <= DEPTH; n++) begin
            tx_push = 1'b1; tx_pdata = 8'(n + 64); cyc();
            chk("R8 tx_irq", int'(tx_irq), int'(n < tx_t16[c]));
         end
         tx_push = 1'b1; cyc();
         chk("R10 tx_ovr", int'(tx_ovr), 1);
         tx_pop = 1'b1; cyc();
         chk("R11 tx data", int'(tx_rdata), 65);
      end

      // R9 non-extended: code ignored, irq means empty
      ext_mode = 1'b0;
      wr_ctl(8'h35);
      chk("R9 empty irq", int'(tx_irq), 1);
      tx_push = 1'b1; tx_pdata = 8'h11; cyc();
      chk("R9 one byte no irq", int'(tx_irq), 0);
      tx_push = 1'b1; tx_pdata = 8'h12; cyc();
      chk("R9 two bytes no irq", int'(tx_irq), 0);

      // R4 receive clear overrides push, tx untouched, not sticky
      rx_push = 1'b1; rx_pdata = 8'h21; cyc();
      rx_push = 1'b1; rx_pdata = 8'h22; cyc();
      ctl_we = 1'b1; ctl_wdata = 8'h33; rx_push = 1'b1; rx_pdata = 8'h23; cyc();
      chk("R4 rx empty after clear+push", int'(rx_level), 0);
      chk("R4 tx untouched", int'(tx_level), 2);
      rx_push = 1'b1; rx_pdata = 8'h24; cyc();
      chk("R4 self-clearing", int'(rx_level), 1);

      // R5 transmit clear overrides pop, rx untouched
      ctl_we = 1'b1; ctl_wdata = 8'h35; tx_pop = 1'b1; cyc();
      chk("R5 tx empty", int'(tx_level), 0);
      chk("R5 tx rdata cleared not popped", int'(tx_rdata), 0);
      chk("R5 rx untouched", int'(rx_level), 1);

      // R6 bit 3 has no effect
      wr_ctl(8'h39);
      chk("R6 rx level", int'(rx_level), 1);
      chk("R6 rx_irq (code 0)", int'(rx_irq), 1);
      chk("R6 tx level", int'(tx_level), 0);
      chk("R6 tx_irq", int'(tx_irq), 1);

      // R3 bit 0 = 0 empties both
      tx_push = 1'b1; tx_pdata = 8'h44; cyc();
      ctl_we = 1'b1; ctl_wdata = 8'h00; rx_push = 1'b1; tx_push = 1'b1; cyc();
      chk("R3 rx flushed", int'(rx_level), 0);
      chk("R3 tx flushed", int'(tx_level), 0);
      tx_push = 1'b1; tx_pdata = 8'h51; cyc();
      tx_push = 1'b1; tx_pdata = 8'h52; cyc();
      chk("R2 tx hold after disable", int'(tx_level), 1);
      chk("R10 tx ovr in hold", int'(tx_ovr), 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule